// File: doc/BRIEF.md
# ECC Error Capture Status Register

This block is a 64-bit status register that records ECC errors reported by a cache data array. In any cycle the array may present one error event. An event carries a single-bit flag, a double-bit flag, the array index, the way group and the cache-line half that failed. The register keeps a sticky flag for each error class and a saturating error count. It also holds the location of the first error it saw. A fatal (double-bit) error is allowed to replace a recorded non-fatal location, because the fatal location matters more.

Software sees the register through a plain read/write port. The read data shows the live register contents. A write replaces every writable field at the next clock edge. Writing zero to both flags re-arms first-error capture.

The event input is a valid-qualified stream with no ready signal. The logger never applies back-pressure, so an event is taken in every cycle that `evt_valid` is high. The source does not need to hold or repeat an event.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset, every bit of `csr_rdata` is zero.
- R2: Field positions in `csr_rdata` and `csr_wdata` are as follows. Bits 42:32 hold the 11-bit index. Bits 31:16 hold the 16-bit count. Bit 9 is the line half. Bits 8:2 hold the 7-bit way group. Bit 1 is the double-bit flag and bit 0 is the single-bit flag. Bits 63:43 and 15:10 always read zero, even after a write of ones.
- R3: The single-bit flag (bit 0) is set by a single-bit-only event and then stays set until software writes it.
- R4: The double-bit flag (bit 1) is set by any event whose double-bit flag is high and then stays set until software writes it.
- R5: Each accepted error event adds one to the count. An event that raises both error flags counts once and is handled as a double-bit error.
- R6: The count saturates at 0xFFFF and never wraps.
- R7: While both flags are clear, an error event loads index, way and half from the event.
- R8: A double-bit event that arrives while only the single-bit flag is set replaces index, way and half.
- R9: Once the double-bit flag is set, no event changes index, way or half. A single-bit event never replaces a recorded location.
- R10: A write loads index, count, half, way and both flags from `csr_wdata`. Writing both flags as zero makes the next event a first error again.
- R11: When a write and an event occur in the same cycle, the write is applied first and the event is then processed against the written values.
- R12: A cycle with `evt_valid` low, or with both event error flags low, leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Error event present this cycle |
| evt_single | input | 1 | Event reports a single-bit error |
| evt_double | input | 1 | Event reports a double or multi-bit error |
| evt_index | input | 11 | Array index of the event |
| evt_way | input | 7 | Way group of the event |
| evt_half | input | 1 | Cache-line half of the event |
| csr_wr_en | input | 1 | Software write strobe |
| csr_wdata | input | 64 | Software write data |
| csr_rdata | output | 64 | Current register contents |

## Verification
The bench checks the order in which the location is replaced. It sends a sequence of single, double, double and then single events to different locations. A design that let later events overwrite the location, or that ignored the fatal upgrade, would report the wrong index and way.

The bench also drives a software write and an event in the same cycle. A design that dropped the event, or evaluated it against the old flags, would show a stale count or location.

It then takes the count across 0xFFFF, where a wrapping counter would read zero. Finally it writes ones into the reserved bits, which must still read zero.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int REG_W    = 64;
  localparam int IDX_W    = 11;
  localparam int WAY_W    = 7;
  localparam int CNT_W    = 16;
  localparam int SB_POS   = 0;
  localparam int DB_POS   = 1;
  localparam int WAY_LO   = 2;
  localparam int HALF_POS = WAY_LO + WAY_W;
  localparam int CNT_LO   = 16;
  localparam int IDX_LO   = 32;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_SINGLE = 2'd1,
    EV_DOUBLE = 2'd2
  } ev_kind_e;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] cnt;
    logic             half;
    logic [WAY_W-1:0] way;
    logic             db;
    logic             sb;
  } log_fields_t;

  function automatic logic [REG_W-1:0] pack_fields(log_fields_t f);
    logic [REG_W-1:0] r;
    r = '0;
    r[SB_POS]                  = f.sb;
    r[DB_POS]                  = f.db;
    r[WAY_LO +: WAY_W]         = f.way;
    r[HALF_POS]                = f.half;
    r[CNT_LO +: CNT_W]         = f.cnt;
    r[IDX_LO +: IDX_W]         = f.idx;
    return r;
  endfunction

  function automatic log_fields_t unpack_fields(logic [REG_W-1:0] r);
    log_fields_t f;
    f.sb   = r[SB_POS];
    f.db   = r[DB_POS];
    f.way  = r[WAY_LO +: WAY_W];
    f.half = r[HALF_POS];
    f.cnt  = r[CNT_LO +: CNT_W];
    f.idx  = r[IDX_LO +: IDX_W];
    return f;
  endfunction
endpackage

// File: rtl/ecc_evt_classify.sv
module ecc_evt_classify
  import ecc_log_pkg::*;
(
  input  logic     valid,
  input  logic     single_err,
  input  logic     double_err,
  output ev_kind_e kind
);
  // A combined report is treated as fatal (R5).
  always_comb begin
    if (!valid)          kind = EV_NONE;
    else if (double_err) kind = EV_DOUBLE;
    else if (single_err) kind = EV_SINGLE;
    else                 kind = EV_NONE;
  end
endmodule

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] base;
  logic [W-1:0] nxt;

  always_comb begin
    base = load ? load_val : cnt;
    nxt  = (inc && base != MAX) ? base + 1'b1 : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !load && cnt != MAX |=> cnt == W'($past(cnt) + 1'b1));

  a_r6_count_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    !load && cnt == MAX |=> cnt == MAX);

  a_r12_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !inc |=> $stable(cnt));
endmodule

// File: rtl/ecc_loc_capture.sv
module ecc_loc_capture
  import ecc_log_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int WW = WAY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          wr_sb,
  input  logic          wr_db,
  input  logic [IW-1:0] wr_idx,
  input  logic [WW-1:0] wr_way,
  input  logic          wr_half,
  input  ev_kind_e      kind,
  input  logic [IW-1:0] ev_idx,
  input  logic [WW-1:0] ev_way,
  input  logic          ev_half,
  output logic          sb,
  output logic          db,
  output logic [IW-1:0] idx,
  output logic [WW-1:0] way,
  output logic          half
);
  logic          b_sb, b_db, b_half;
  logic [IW-1:0] b_idx;
  logic [WW-1:0] b_way;
  logic          n_sb, n_db, n_half;
  logic [IW-1:0] n_idx;
  logic [WW-1:0] n_way;
  logic          take_loc;

  // Software write first, then the event on top of it (R11).
  always_comb begin
    b_sb   = wr ? wr_sb   : sb;
    b_db   = wr ? wr_db   : db;
    b_idx  = wr ? wr_idx  : idx;
    b_way  = wr ? wr_way  : way;
    b_half = wr ? wr_half : half;

    take_loc = (kind != EV_NONE) && !b_db && (kind == EV_DOUBLE || !b_sb);

    n_sb   = b_sb | (kind == EV_SINGLE);
    n_db   = b_db | (kind == EV_DOUBLE);
    n_idx  = take_loc ? ev_idx  : b_idx;
    n_way  = take_loc ? ev_way  : b_way;
    n_half = take_loc ? ev_half : b_half;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb   <= 1'b0;
      db   <= 1'b0;
      idx  <= '0;
      way  <= '0;
      half <= 1'b0;
    end else begin
      sb   <= n_sb;
      db   <= n_db;
      idx  <= n_idx;
      way  <= n_way;
      half <= n_half;
    end
  end

  a_r3_single_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sb && !wr |=> sb);

  a_r4_double_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    db && !wr |=> db);

  a_r9_location_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    db && !wr |=> $stable(idx) && $stable(way) && $stable(half));

  a_r8_fatal_replaces: assert property (@(posedge clk) disable iff (!rst_n)
    kind == EV_DOUBLE && !wr && !db |=> idx == $past(ev_idx) && way == $past(ev_way));

  a_r7_first_capture: assert property (@(posedge clk) disable iff (!rst_n)
    kind == EV_SINGLE && !wr && !db && !sb |=> idx == $past(ev_idx) && half == $past(ev_half));
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic             evt_single,
  input  logic             evt_double,
  input  logic [IDX_W-1:0] evt_index,
  input  logic [WAY_W-1:0] evt_way,
  input  logic             evt_half,
  input  logic             csr_wr_en,
  input  logic [REG_W-1:0] csr_wdata,
  output logic [REG_W-1:0] csr_rdata
);
  log_fields_t wr_f;
  log_fields_t cur_f;
  ev_kind_e    kind;
  logic        unused_wbits;

  assign wr_f         = unpack_fields(csr_wdata);
  assign unused_wbits = ^{csr_wdata[REG_W-1:IDX_LO+IDX_W], csr_wdata[CNT_LO-1:HALF_POS+1]};

  ecc_evt_classify u_classify (
    .valid      (evt_valid),
    .single_err (evt_single),
    .double_err (evt_double),
    .kind       (kind)
  );

  ecc_sat_counter #(.W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (csr_wr_en),
    .load_val (wr_f.cnt),
    .inc      (kind != EV_NONE),
    .cnt      (cur_f.cnt)
  );

  ecc_loc_capture #(.IW(IDX_W), .WW(WAY_W)) u_loc (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (csr_wr_en),
    .wr_sb   (wr_f.sb),
    .wr_db   (wr_f.db),
    .wr_idx  (wr_f.idx),
    .wr_way  (wr_f.way),
    .wr_half (wr_f.half),
    .kind    (kind),
    .ev_idx  (evt_index),
    .ev_way  (evt_way),
    .ev_half (evt_half),
    .sb      (cur_f.sb),
    .db      (cur_f.db),
    .idx     (cur_f.idx),
    .way     (cur_f.way),
    .half    (cur_f.half)
  );

  assign csr_rdata = pack_fields(cur_f);

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_wr_en && kind == EV_NONE |=> $stable(csr_rdata));

  a_r10_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr_en && kind == EV_NONE |=> csr_rdata[IDX_LO+IDX_W-1:0] == $past(csr_wdata[IDX_LO+IDX_W-1:0] & 43'h7FF_FFFF_03FF));
endmodule

// File: tb/ecc_err_logger_tb.sv
`timescale 1ns/1ps
module ecc_err_logger_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0, evt_single = 1'b0, evt_double = 1'b0, evt_half = 1'b0;
  logic [10:0] evt_index = '0;
  logic [6:0]  evt_way = '0;
  logic        csr_wr_en = 1'b0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;

  localparam logic [63:0] RW_MASK = 64'h0000_07FF_FFFF_03FF;

  typedef struct {
    logic [63:0] val;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [63:0] model = '0;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  ecc_err_logger u_dut (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(evt_valid), .evt_single(evt_single), .evt_double(evt_double),
    .evt_index(evt_index), .evt_way(evt_way), .evt_half(evt_half),
    .csr_wr_en(csr_wr_en), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
  );

  function automatic logic [63:0] predict(logic [63:0] cur, bit wr, logic [63:0] wd,
                                          bit v, bit s, bit d, logic [10:0] ix,
                                          logic [6:0] wy, bit hf);
    logic [63:0] b;
    b = wr ? (wd & RW_MASK) : cur;
    if (v && (s || d)) begin
      if (!b[1] && (d || !b[0])) begin
        b[42:32] = ix;
        b[8:2]   = wy;
        b[9]     = hf;
      end
      if (b[31:16] != 16'hFFFF) b[31:16] = b[31:16] + 16'd1;
      if (d) b[1] = 1'b1;
      else   b[0] = 1'b1;
    end
    return b;
  endfunction

  task automatic step(string tag, bit wr, logic [63:0] wd, bit v, bit s, bit d,
                      logic [10:0] ix, logic [6:0] wy, bit hf);
    exp_t e;
    @(negedge clk);
    csr_wr_en = wr; csr_wdata = wd;
    evt_valid = v; evt_single = s; evt_double = d;
    evt_index = ix; evt_way = wy; evt_half = hf;
    model = predict(model, wr, wd, v, s, d, ix, wy, hf);
    @(posedge clk);
    #1;
    e.val = model;
    e.tag = tag;
    sb_q.push_back(e);
    csr_wr_en = 1'b0; evt_valid = 1'b0; evt_single = 1'b0; evt_double = 1'b0;
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_cmp++;
      if (csr_rdata !== e.val) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", e.tag, csr_rdata, e.val);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (csr_rdata !== 64'h0) begin
      n_bad++;
      $display("FAIL R1 reset: actual %h expected %h", csr_rdata, 64'h0);
    end
    rst_n = 1'b1;

    step("R12 valid low",       0, 0, 0, 1, 1, 11'h7FF, 7'h7F, 1);
    step("R12 no error flags",  0, 0, 1, 0, 0, 11'h7FF, 7'h7F, 1);
    step("R7 first single",     0, 0, 1, 1, 0, 11'h155, 7'h2A, 1);
    step("R9 R3 second single", 0, 0, 1, 1, 0, 11'h0AA, 7'h15, 0);
    step("R8 R4 fatal replace", 0, 0, 1, 0, 1, 11'h3C3, 7'h5A, 0);
    step("R9 fatal frozen",     0, 0, 1, 0, 1, 11'h011, 7'h01, 1);
    step("R9 single frozen",    0, 0, 1, 1, 0, 11'h022, 7'h02, 1);
    step("R3 R4 sticky idle",   0, 0, 0, 0, 0, 11'h0,   7'h0,  0);
    step("R10 write zeros",     1, 64'h0, 0, 0, 0, 11'h0, 7'h0, 0);
    step("R5 combined once",    0, 0, 1, 1, 1, 11'h456, 7'h33, 1);
    step("R10 rearm write",     1, 64'h0000_0123_0005_0000 | (64'h1 << 9) | (64'h11 << 2), 0, 0, 0, 11'h0, 7'h0, 0);
    step("R10 recapture",       0, 0, 1, 1, 0, 11'h70F, 7'h44, 0);
    step("R11 write sb + fatal",1, 64'h0000_0200_0010_0001, 1, 0, 1, 11'h10F, 7'h6E, 1);
    step("R11 write db + single",1,64'h0000_0300_0020_0002 | (64'h7 << 2), 1, 1, 0, 11'h001, 7'h01, 1);
    step("R2 reserved ones",    1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 11'h0, 7'h0, 0);
    step("R6 saturated event",  0, 0, 1, 1, 0, 11'h0, 7'h0, 0);
    step("R6 load near max",    1, 64'h0000_0000_FFFE_0000, 0, 0, 0, 11'h0, 7'h0, 0);
    step("R6 reach max",        0, 0, 1, 1, 0, 11'h00F, 7'h0F, 0);
    step("R6 hold max",         0, 0, 1, 0, 1, 11'h0F0, 7'h70, 1);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule